// File: doc/BRIEF.md
# SMBus Transaction Sequencer

This block turns a one-cycle start request from a register unit into the ordered list of byte-level bus operations that one SMBus transaction needs. It captures the protocol code, the address byte (seven-bit target address plus a direction flag in bit 0), the command byte and two data bytes when the start is taken. It then steps through a short per-protocol program. Each step is either a bus operation handed to a byte master (start with address, send byte, receive byte, stop) or a final step that reports the outcome.

Received bytes come back through write strobes for the data0 and data1 registers and for the block buffer. A transaction ends with exactly one result pulse. The pulse is one of: completion (interrupt), device error, handoff to the block buffer unit, or byte-done for the first byte of a raw block read. Block transfers hand over once the count byte has been sent or received. The raw block read variant always addresses the target for writing first, sends data1 as its command byte and then restarts in the read direction, whatever the direction flag says.

Top module: `smb_txn_sequencer`

## Requirements
- R1: After reset, busy, the bus request and every strobe and result pulse are low.
- R2: Quick command (code 0) issues a start carrying the captured address byte unchanged, then a stop, and ends with the interrupt pulse. Bus operation codes are 0 start, 1 send, 2 receive, 3 stop.
- R3: Byte protocol (code 1) with the direction flag set issues a start with the address byte, a receive flagged as last (NACK) whose byte is written to data0, a stop, and interrupt. With the flag clear it issues the start, sends the command byte, issues a stop, and ends with interrupt.
- R4: Byte data (2) and word data (3) start in the write direction (bit 0 forced to 0) and send the command byte. Writes then send data0 and, for word data, data1, followed by a stop. Reads restart with bit 0 forced to 1. A byte data read receives one last byte into data0. A word read receives the low byte into data0 with ACK and the high byte into data1 with NACK. Both finish with a stop and interrupt.
- R5: Block data (5) starts for writing and sends the command byte. A read then restarts for reading and receives the count byte with ACK into data0. A write sends data0 as the count. Both end with the handoff pulse and no stop.
- R6: Raw block read (6) starts in the write direction even when bit 0 is set, sends data1, restarts in the read direction and receives the first byte with ACK onto the block strobe. It ends with the byte-done pulse and no stop.
- R7: Codes 4 and 7 issue no bus operation and end with the device error pulse.
- R8: A NACK on a start or send step is followed at once by a stop, and the transaction then ends with device error and no interrupt.
- R9: Busy stays high from the accepted start to the end. A start pulse while busy is ignored. Operands changed during a transaction do not affect it. A bus request stays high with stable operation and data until the byte master reports done.
- R10: Each transaction produces exactly one result pulse, in the first cycle after busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | One-cycle transaction request |
| proto_i | input | 3 | Protocol code |
| addr_i | input | 8 | Target address in bits 7:1, read flag in bit 0 |
| cmd_i | input | 8 | Command byte |
| data0_i | input | 8 | Data0 register value |
| data1_i | input | 8 | Data1 register value |
| busy_o | output | 1 | Transaction in progress |
| bm_req_o | output | 1 | Byte master request, held until done |
| bm_op_o | output | 2 | Bus operation code |
| bm_wdata_o | output | 8 | Address byte or data byte to send |
| bm_nack_o | output | 1 | Receive is the last byte (answer with NACK) |
| bm_done_i | input | 1 | Byte master finished the requested operation |
| bm_ack_i | input | 1 | Target acknowledged the start or send |
| bm_rdata_i | input | 8 | Byte received by the byte master |
| rx_data_o | output | 8 | Received byte for the write strobes |
| data0_we_o | output | 1 | Write rx_data_o into data0 |
| data1_we_o | output | 1 | Write rx_data_o into data1 |
| blk_we_o | output | 1 | Write rx_data_o into the block byte register |
| intr_o | output | 1 | Result pulse: completed |
| dev_err_o | output | 1 | Result pulse: device error |
| handoff_o | output | 1 | Result pulse: block buffer unit takes over |
| byte_done_o | output | 1 | Result pulse: first raw block byte ready |

## Verification
The embedded properties check several rules on every cycle: requests stay stable until the byte master answers, no request appears outside busy, at most one result pulse fires and it fires only once busy is low, and a stop follows directly after a refused start or send. The bench scenarios are the only place where each protocol program is shown to issue the right operations in the right order. They also show which address byte, direction and data go out, where received bytes land, and that stray starts and operand changes during a transaction leave it untouched.

// File: rtl/smb_seq_pkg.sv
package smb_seq_pkg;

  typedef enum logic [1:0] {
    BOP_START = 2'd0,
    BOP_SEND  = 2'd1,
    BOP_RECV  = 2'd2,
    BOP_STOP  = 2'd3
  } bus_op_e;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_ADDR_RAW,
    SRC_ADDR_W,
    SRC_ADDR_R,
    SRC_CMD,
    SRC_D0,
    SRC_D1
  } src_e;

  typedef enum logic [1:0] {
    DST_NONE,
    DST_D0,
    DST_D1,
    DST_BLK
  } dst_e;

  typedef enum logic [2:0] {
    FIN_NONE,
    FIN_INTR,
    FIN_ERR,
    FIN_HANDOFF,
    FIN_BYTE
  } fin_e;

  typedef enum logic [3:0] {
    PG_QUICK, PG_BYTE_RD, PG_BYTE_WR, PG_BD_RD, PG_BD_WR,
    PG_WD_RD, PG_WD_WR, PG_BLK_RD, PG_BLK_WR, PG_RAW_BLK, PG_BAD
  } prog_e;

  typedef struct packed {
    logic    is_fin;
    bus_op_e op;
    src_e    src;
    dst_e    dst;
    logic    nack;
    fin_e    fin;
  } uop_t;

  function automatic uop_t u_bus(bus_op_e op, src_e src, dst_e dst, logic nack);
    uop_t u;
    u.is_fin = 1'b0;
    u.op     = op;
    u.src    = src;
    u.dst    = dst;
    u.nack   = nack;
    u.fin    = FIN_NONE;
    return u;
  endfunction

  function automatic uop_t u_end(fin_e f);
    uop_t u;
    u.is_fin = 1'b1;
    u.op     = BOP_STOP;
    u.src    = SRC_NONE;
    u.dst    = DST_NONE;
    u.nack   = 1'b0;
    u.fin    = f;
    return u;
  endfunction

endpackage

// File: rtl/smb_seq_program.sv
module smb_seq_program
  import smb_seq_pkg::*;
#(
  parameter int PROTO_W = 3,
  parameter int STEP_W  = 3
) (
  input  logic [PROTO_W-1:0] proto_i,
  input  logic               rd_i,
  input  logic [STEP_W-1:0]  step_i,
  output uop_t               uop_o
);

  prog_e prog;

  always_comb begin
    case (proto_i)
      3'd0:    prog = PG_QUICK;
      3'd1:    prog = rd_i ? PG_BYTE_RD : PG_BYTE_WR;
      3'd2:    prog = rd_i ? PG_BD_RD   : PG_BD_WR;
      3'd3:    prog = rd_i ? PG_WD_RD   : PG_WD_WR;
      3'd5:    prog = rd_i ? PG_BLK_RD  : PG_BLK_WR;
      3'd6:    prog = PG_RAW_BLK;
      default: prog = PG_BAD;
    endcase
  end

  always_comb begin
    uop_o = u_end(FIN_ERR);
    case (prog)
      PG_QUICK: case (step_i)
        3'd0: uop_o = u_bus(BOP_START, SRC_ADDR_RAW, DST_NONE, 1'b0);
        3'd1: uop_o = u_bus(BOP_STOP,  SRC_NONE,     DST_NONE, 1'b0);
        3'd2: uop_o = u_end(FIN_INTR);
        default: ;
      endcase
      PG_BYTE_RD: case (step_i)
        3'd0: uop_o = u_bus(BOP_START, SRC_ADDR_RAW, DST_NONE, 1'b0);
        3'd1: uop_o = u_bus(BOP_RECV,  SRC_NONE,     DST_D0,   1'b1);
        3'd2: uop_o = u_bus(BOP_STOP,  SRC_NONE,     DST_NONE, 1'b0);
        3'd3: uop_o = u_end(FIN_INTR);
        default: ;
      endcase
      PG_BYTE_WR: case (step_i)
        3'd0: uop_o = u_bus(BOP_START, SRC_ADDR_RAW, DST_NONE, 1'b0);
        3'd1: uop_o = u_bus(BOP_SEND,  SRC_CMD,      DST_NONE, 1'b0);
        3'd2: uop_o = u_bus(BOP_STOP,  SRC_NONE,     DST_NONE, 1'b0);
        3'd3: uop_o = u_end(FIN_INTR);
        default: ;
      endcase
      PG_BD_RD: case (step_i)
        3'd0: uop_o = u_bus(BOP_START, SRC_ADDR_W, DST_NONE, 1'b0);
        3'd1: uop_o = u_bus(BOP_SEND,  SRC_CMD,    DST_NONE, 1'b0);
        3'd2: uop_o = u_bus(BOP_START, SRC_ADDR_R, DST_NONE, 1'b0);
        3'd3: uop_o = u_bus(BOP_RECV,  SRC_NONE,   DST_D0,   1'b1);
        3'd4: uop_o = u_bus(BOP_STOP,  SRC_NONE,   DST_NONE, 1'b0);
        3'd5: uop_o = u_end(FIN_INTR);
        default: ;
      endcase
      PG_BD_WR: case (step_i)
        3'd0: uop_o = u_bus(BOP_START, SRC_ADDR_W, DST_NONE, 1'b0);
        3'd1: uop_o = u_bus(BOP_SEND,  SRC_CMD,    DST_NONE, 1'b0);
        3'd2: uop_o = u_bus(BOP_SEND,  SRC_D0,     DST_NONE, 1'b0);
        3'd3: uop_o = u_bus(BOP_STOP,  SRC_NONE,   DST_NONE, 1'b0);
        3'd4: uop_o = u_end(FIN_INTR);
        default: ;
      endcase
      PG_WD_RD: case (step_i)
        3'd0: uop_o = u_bus(BOP_START, SRC_ADDR_W, DST_NONE, 1'b0);
        3'd1: uop_o = u_bus(BOP_SEND,  SRC_CMD,    DST_NONE, 1'b0);
        3'd2: uop_o = u_bus(BOP_START, SRC_ADDR_R, DST_NONE, 1'b0);
        3'd3: uop_o = u_bus(BOP_RECV,  SRC_NONE,   DST_D0,   1'b0);
        3'd4: uop_o = u_bus(BOP_RECV,  SRC_NONE,   DST_D1,   1'b1);
        3'd5: uop_o = u_bus(BOP_STOP,  SRC_NONE,   DST_NONE, 1'b0);
        3'd6: uop_o = u_end(FIN_INTR);
        default: ;
      endcase
      PG_WD_WR: case (step_i)
        3'd0: uop_o = u_bus(BOP_START, SRC_ADDR_W, DST_NONE, 1'b0);
        3'd1: uop_o = u_bus(BOP_SEND,  SRC_CMD,    DST_NONE, 1'b0);
        3'd2: uop_o = u_bus(BOP_SEND,  SRC_D0,     DST_NONE, 1'b0);
        3'd3: uop_o = u_bus(BOP_SEND,  SRC_D1,     DST_NONE, 1'b0);
        3'd4: uop_o = u_bus(BOP_STOP,  SRC_NONE,   DST_NONE, 1'b0);
        3'd5: uop_o = u_end(FIN_INTR);
        default: ;
      endcase
      PG_BLK_RD: case (step_i)
        3'd0: uop_o = u_bus(BOP_START, SRC_ADDR_W, DST_NONE, 1'b0);
        3'd1: uop_o = u_bus(BOP_SEND,  SRC_CMD,    DST_NONE, 1'b0);
        3'd2: uop_o = u_bus(BOP_START, SRC_ADDR_R, DST_NONE, 1'b0);
        3'd3: uop_o = u_bus(BOP_RECV,  SRC_NONE,   DST_D0,   1'b0);
        3'd4: uop_o = u_end(FIN_HANDOFF);
        default: ;
      endcase
      PG_BLK_WR: case (step_i)
        3'd0: uop_o = u_bus(BOP_START, SRC_ADDR_W, DST_NONE, 1'b0);
        3'd1: uop_o = u_bus(BOP_SEND,  SRC_CMD,    DST_NONE, 1'b0);
        3'd2: uop_o = u_bus(BOP_SEND,  SRC_D0,     DST_NONE, 1'b0);
        3'd3: uop_o = u_end(FIN_HANDOFF);
        default: ;
      endcase
      PG_RAW_BLK: case (step_i)
        3'd0: uop_o = u_bus(BOP_START, SRC_ADDR_W, DST_NONE, 1'b0);
        3'd1: uop_o = u_bus(BOP_SEND,  SRC_D1,     DST_NONE, 1'b0);
        3'd2: uop_o = u_bus(BOP_START, SRC_ADDR_R, DST_NONE, 1'b0);
        3'd3: uop_o = u_bus(BOP_RECV,  SRC_NONE,   DST_BLK,  1'b0);
        3'd4: uop_o = u_end(FIN_BYTE);
        default: ;
      endcase
      default: uop_o = u_end(FIN_ERR);
    endcase
  end

endmodule

// File: rtl/smb_seq_operands.sv
module smb_seq_operands
  import smb_seq_pkg::*;
#(
  parameter int PROTO_W = 3,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_en_i,
  input  logic [PROTO_W-1:0] proto_i,
  input  logic [DATA_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  cmd_i,
  input  logic [DATA_W-1:0]  data0_i,
  input  logic [DATA_W-1:0]  data1_i,
  input  src_e               src_i,
  output logic [PROTO_W-1:0] proto_o,
  output logic               rd_o,
  output logic [DATA_W-1:0]  wdata_o
);

  localparam int TGT_W = DATA_W - 1;

  logic [PROTO_W-1:0] proto_q;
  logic [DATA_W-1:0]  addr_q, cmd_q, d0_q, d1_q;
  logic [TGT_W-1:0]   tgt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      proto_q <= '0;
      addr_q  <= '0;
      cmd_q   <= '0;
      d0_q    <= '0;
      d1_q    <= '0;
    end else if (cap_en_i) begin
      proto_q <= proto_i;
      addr_q  <= addr_i;
      cmd_q   <= cmd_i;
      d0_q    <= data0_i;
      d1_q    <= data1_i;
    end
  end

  assign tgt     = addr_q[DATA_W-1:1];
  assign proto_o = proto_q;
  assign rd_o    = addr_q[0];

  always_comb begin
    case (src_i)
      SRC_ADDR_RAW: wdata_o = addr_q;
      SRC_ADDR_W:   wdata_o = {tgt, 1'b0};
      SRC_ADDR_R:   wdata_o = {tgt, 1'b1};
      SRC_CMD:      wdata_o = cmd_q;
      SRC_D0:       wdata_o = d0_q;
      SRC_D1:       wdata_o = d1_q;
      default:      wdata_o = '0;
    endcase
  end

endmodule

// File: rtl/smb_seq_engine.sv
module smb_seq_engine
  import smb_seq_pkg::*;
#(
  parameter int STEP_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  uop_t              uop_i,
  input  logic              bm_done_i,
  input  logic              bm_ack_i,
  input  logic [DATA_W-1:0] bm_rdata_i,
  output logic              cap_en_o,
  output logic [STEP_W-1:0] step_o,
  output src_e              src_o,
  output logic              busy_o,
  output logic              bm_req_o,
  output bus_op_e           bm_op_o,
  output logic              bm_nack_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              data0_we_o,
  output logic              data1_we_o,
  output logic              blk_we_o,
  output logic              intr_o,
  output logic              dev_err_o,
  output logic              handoff_o,
  output logic              byte_done_o
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_ABORT} st_e;

  st_e               state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [DATA_W-1:0] rx_q;
  logic              rx_en;
  logic              d0_we_d, d1_we_d, blk_we_d;
  logic              intr_d, err_d, hand_d, byte_d;
  logic              d0_we_q, d1_we_q, blk_we_q;
  logic              intr_q, err_q, hand_q, byte_q;
  logic              refused;

  assign refused = (uop_i.op == BOP_START || uop_i.op == BOP_SEND) && !bm_ack_i;

  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    cap_en_o = 1'b0;
    rx_en    = 1'b0;
    d0_we_d  = 1'b0;
    d1_we_d  = 1'b0;
    blk_we_d = 1'b0;
    intr_d   = 1'b0;
    err_d    = 1'b0;
    hand_d   = 1'b0;
    byte_d   = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) begin
        state_d  = ST_RUN;
        step_d   = '0;
        cap_en_o = 1'b1;
      end
      ST_RUN: begin
        if (uop_i.is_fin) begin
          state_d = ST_IDLE;
          intr_d  = (uop_i.fin == FIN_INTR);
          err_d   = (uop_i.fin == FIN_ERR);
          hand_d  = (uop_i.fin == FIN_HANDOFF);
          byte_d  = (uop_i.fin == FIN_BYTE);
        end else if (bm_done_i) begin
          if (refused) begin
            state_d = ST_ABORT;
          end else begin
            step_d = step_q + 1'b1;
            if (uop_i.op == BOP_RECV) begin
              rx_en    = 1'b1;
              d0_we_d  = (uop_i.dst == DST_D0);
              d1_we_d  = (uop_i.dst == DST_D1);
              blk_we_d = (uop_i.dst == DST_BLK);
            end
          end
        end
      end
      ST_ABORT: if (bm_done_i) begin
        state_d = ST_IDLE;
        err_d   = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      step_q   <= '0;
      d0_we_q  <= 1'b0;
      d1_we_q  <= 1'b0;
      blk_we_q <= 1'b0;
      intr_q   <= 1'b0;
      err_q    <= 1'b0;
      hand_q   <= 1'b0;
      byte_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      step_q   <= step_d;
      d0_we_q  <= d0_we_d;
      d1_we_q  <= d1_we_d;
      blk_we_q <= blk_we_d;
      intr_q   <= intr_d;
      err_q    <= err_d;
      hand_q   <= hand_d;
      byte_q   <= byte_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rx_q <= '0;
    else if (rx_en) rx_q <= bm_rdata_i;
  end

  assign step_o      = step_q;
  assign src_o       = (state_q == ST_RUN) ? uop_i.src : SRC_NONE;
  assign busy_o      = (state_q != ST_IDLE);
  assign bm_req_o    = (state_q == ST_ABORT) || (state_q == ST_RUN && !uop_i.is_fin);
  assign bm_op_o     = (state_q == ST_ABORT) ? BOP_STOP : uop_i.op;
  assign bm_nack_o   = (state_q == ST_RUN) && uop_i.nack;
  assign rx_data_o   = rx_q;
  assign data0_we_o  = d0_we_q;
  assign data1_we_o  = d1_we_q;
  assign blk_we_o    = blk_we_q;
  assign intr_o      = intr_q;
  assign dev_err_o   = err_q;
  assign handoff_o   = hand_q;
  assign byte_done_o = byte_q;

  // R8: a refused start or send is followed directly by a stop request
  a_r8_stop_after_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_req_o && bm_done_i && !bm_ack_i && state_q == ST_RUN &&
     (bm_op_o == BOP_START || bm_op_o == BOP_SEND))
    |=> (bm_req_o && bm_op_o == BOP_STOP));

  // R8: abort ends in device error only
  a_r8_abort_err: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ABORT && bm_done_i) |=> (dev_err_o && !intr_o));

  // R10: at most one result pulse, and only once idle
  a_r10_one_result: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({intr_o, dev_err_o, handoff_o, byte_done_o}));

  a_r10_result_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_o || dev_err_o || handoff_o || byte_done_o) |-> !busy_o);

endmodule

// File: rtl/smb_txn_sequencer.sv
module smb_txn_sequencer
  import smb_seq_pkg::*;
#(
  parameter int PROTO_W = 3,
  parameter int DATA_W  = 8,
  parameter int STEP_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [PROTO_W-1:0] proto_i,
  input  logic [DATA_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  cmd_i,
  input  logic [DATA_W-1:0]  data0_i,
  input  logic [DATA_W-1:0]  data1_i,
  output logic               busy_o,
  output logic               bm_req_o,
  output logic [1:0]         bm_op_o,
  output logic [DATA_W-1:0]  bm_wdata_o,
  output logic               bm_nack_o,
  input  logic               bm_done_i,
  input  logic               bm_ack_i,
  input  logic [DATA_W-1:0]  bm_rdata_i,
  output logic [DATA_W-1:0]  rx_data_o,
  output logic               data0_we_o,
  output logic               data1_we_o,
  output logic               blk_we_o,
  output logic               intr_o,
  output logic               dev_err_o,
  output logic               handoff_o,
  output logic               byte_done_o
);

  uop_t               uop;
  src_e               src;
  bus_op_e            op;
  logic               cap_en;
  logic [STEP_W-1:0]  step;
  logic [PROTO_W-1:0] proto_q;
  logic               rd_q;

  smb_seq_operands #(.PROTO_W(PROTO_W), .DATA_W(DATA_W)) u_opnd (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en_i (cap_en),
    .proto_i  (proto_i),
    .addr_i   (addr_i),
    .cmd_i    (cmd_i),
    .data0_i  (data0_i),
    .data1_i  (data1_i),
    .src_i    (src),
    .proto_o  (proto_q),
    .rd_o     (rd_q),
    .wdata_o  (bm_wdata_o)
  );

  smb_seq_program #(.PROTO_W(PROTO_W), .STEP_W(STEP_W)) u_prog (
    .proto_i (proto_q),
    .rd_i    (rd_q),
    .step_i  (step),
    .uop_o   (uop)
  );

  smb_seq_engine #(.STEP_W(STEP_W), .DATA_W(DATA_W)) u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .uop_i       (uop),
    .bm_done_i   (bm_done_i),
    .bm_ack_i    (bm_ack_i),
    .bm_rdata_i  (bm_rdata_i),
    .cap_en_o    (cap_en),
    .step_o      (step),
    .src_o       (src),
    .busy_o      (busy_o),
    .bm_req_o    (bm_req_o),
    .bm_op_o     (op),
    .bm_nack_o   (bm_nack_o),
    .rx_data_o   (rx_data_o),
    .data0_we_o  (data0_we_o),
    .data1_we_o  (data1_we_o),
    .blk_we_o    (blk_we_o),
    .intr_o      (intr_o),
    .dev_err_o   (dev_err_o),
    .handoff_o   (handoff_o),
    .byte_done_o (byte_done_o)
  );

  assign bm_op_o = op;

  // R9: requests only inside a transaction
  a_r9_req_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    bm_req_o |-> busy_o);

  // R9: a pending request holds its operation and data
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_req_o && !bm_done_i) |=> (bm_req_o && $stable(bm_op_o) && $stable(bm_wdata_o)));

  // R9: operands are frozen while busy, whatever the inputs do
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(proto_q));

endmodule

// File: tb/smb_txn_sequencer_tb_top.sv
`timescale 1ns/1ps
module smb_txn_sequencer_tb_top;

  localparam logic [1:0] OP_START = 2'd0, OP_SEND = 2'd1, OP_RECV = 2'd2, OP_STOP = 2'd3;
  localparam int RES_NONE = 0, RES_INTR = 1, RES_ERR = 2, RES_HAND = 3, RES_BYTE = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [2:0] proto;
  logic [7:0] addr, cmd, d0, d1;
  logic       busy, bm_req, bm_nack, bm_done, bm_ack;
  logic [1:0] bm_op;
  logic [7:0] bm_wdata, bm_rdata, rx_data;
  logic       d0_we, d1_we, blk_we, intr, dev_err, handoff, byte_done;

  int checks = 0, fails = 0;
  int cyc = 0;
  logic [10:0] expq[$];
  int op_idx, nack_at, rx_cnt;
  int res_code, res_cnt;
  bit d0_seen, d1_seen, blk_seen;
  logic [7:0] d0_cap, d1_cap, blk_cap;
  string cur_tag;

  always #10 clk = ~clk;

  smb_txn_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .proto_i(proto), .addr_i(addr),
    .cmd_i(cmd), .data0_i(d0), .data1_i(d1), .busy_o(busy), .bm_req_o(bm_req),
    .bm_op_o(bm_op), .bm_wdata_o(bm_wdata), .bm_nack_o(bm_nack), .bm_done_i(bm_done),
    .bm_ack_i(bm_ack), .bm_rdata_i(bm_rdata), .rx_data_o(rx_data), .data0_we_o(d0_we),
    .data1_we_o(d1_we), .blk_we_o(blk_we), .intr_o(intr), .dev_err_o(dev_err),
    .handoff_o(handoff), .byte_done_o(byte_done)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", cur_tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      cur_tag = "watchdog";
      check(1'b0, "run timed out", cyc, 100000);
      finish_run();
    end
  end

  // monitor: byte master model, scoreboard pop and result capture
  always @(negedge clk) begin
    if (rst_n) begin
      if (bm_done) begin
        bm_done = 1'b0;
      end else if (bm_req) begin
        if (expq.size() == 0) begin
          check(1'b0, "unexpected bus op", {bm_op, bm_nack, bm_wdata}, 0);
        end else begin
          logic [10:0] e;
          logic [10:0] a;
          e = expq.pop_front();
          a = {bm_op, bm_nack, (bm_op == OP_START || bm_op == OP_SEND) ? bm_wdata : 8'h00};
          check(a == e, $sformatf("bus op %0d", op_idx), a, e);
        end
        bm_ack   = (op_idx != nack_at);
        bm_rdata = 8'hA0 + 8'(rx_cnt);
        if (bm_op == OP_RECV) rx_cnt++;
        op_idx++;
        bm_done = 1'b1;
      end
      if (d0_we)  begin d0_seen  = 1; d0_cap  = rx_data; end
      if (d1_we)  begin d1_seen  = 1; d1_cap  = rx_data; end
      if (blk_we) begin blk_seen = 1; blk_cap = rx_data; end
      if (intr)      begin res_code = RES_INTR; res_cnt++; end
      if (dev_err)   begin res_code = RES_ERR;  res_cnt++; end
      if (handoff)   begin res_code = RES_HAND; res_cnt++; end
      if (byte_done) begin res_code = RES_BYTE; res_cnt++; end
    end
  end

  task automatic exp_op(input logic [1:0] op, input logic n, input logic [7:0] w);
    expq.push_back({op, n, w});
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  // driver: one transaction, expected bus ops already queued
  task automatic run(input string tag, input logic [2:0] p, input logic [7:0] a,
                     input logic [7:0] c, input logic [7:0] x0, input logic [7:0] x1,
                     input int nk, input bit poke, input int exp_res,
                     input bit e_d0, input logic [7:0] v_d0,
                     input bit e_d1, input logic [7:0] v_d1,
                     input bit e_blk, input logic [7:0] v_blk);
    int n;
    cur_tag = tag;
    op_idx = 0; nack_at = nk; rx_cnt = 0;
    res_code = RES_NONE; res_cnt = 0;
    d0_seen = 0; d1_seen = 0; blk_seen = 0;
    proto = p; addr = a; cmd = c; d0 = x0; d1 = x1;
    start = 1'b1;
    tick();
    start = 1'b0;
    check(busy == 1'b1, "busy after start", busy, 1);
    n = 0;
    while (busy && n < 1000) begin
      if (poke && n == 3) begin
        start = 1'b1; proto = 3'd0; addr = 8'hFF; cmd = 8'hEE; d0 = 8'hDD; d1 = 8'hCC;
      end else begin
        start = 1'b0;
      end
      tick();
      n++;
    end
    start = 1'b0;
    check(n < 1000, "transaction ends", n, 1000);
    tick();
    check(expq.size() == 0, "all expected bus ops seen", expq.size(), 0);
    expq.delete();
    check(res_code == exp_res, "result kind", res_code, exp_res);
    check(res_cnt == 1, "R10 single result pulse", res_cnt, 1);
    check(d0_seen == e_d0 && (!e_d0 || d0_cap == v_d0), "data0 write", {d0_seen, d0_cap}, {e_d0, v_d0});
    check(d1_seen == e_d1 && (!e_d1 || d1_cap == v_d1), "data1 write", {d1_seen, d1_cap}, {e_d1, v_d1});
    check(blk_seen == e_blk && (!e_blk || blk_cap == v_blk), "block write", {blk_seen, blk_cap}, {e_blk, v_blk});
    tick();
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; proto = '0; addr = '0; cmd = '0; d0 = '0; d1 = '0;
    bm_done = 1'b0; bm_ack = 1'b1; bm_rdata = '0;
    nack_at = -1; cur_tag = "R1";
    repeat (3) tick();
    // R1: reset state
    check(!busy && !bm_req, "R1 idle after reset", {busy, bm_req}, 0);
    check(!intr && !dev_err && !handoff && !byte_done && !d0_we && !d1_we && !blk_we,
          "R1 no pulses in reset", {intr, dev_err, handoff, byte_done}, 0);
    rst_n = 1'b1;
    repeat (2) tick();
    check(!busy && !bm_req, "R1 idle after release", {busy, bm_req}, 0);

    // R2: quick command, both directions
    exp_op(OP_START, 0, 8'h50); exp_op(OP_STOP, 0, 8'h00);
    run("R2 quick write", 3'd0, 8'h50, 8'h00, 8'h00, 8'h00, -1, 0, RES_INTR, 0, 0, 0, 0, 0, 0);
    exp_op(OP_START, 0, 8'h51); exp_op(OP_STOP, 0, 8'h00);
    run("R2 quick read", 3'd0, 8'h51, 8'h00, 8'h00, 8'h00, -1, 0, RES_INTR, 0, 0, 0, 0, 0, 0);

    // R3: byte receive and send
    exp_op(OP_START, 0, 8'h35); exp_op(OP_RECV, 1, 8'h00); exp_op(OP_STOP, 0, 8'h00);
    run("R3 byte read", 3'd1, 8'h35, 8'h12, 8'h00, 8'h00, -1, 0, RES_INTR, 1, 8'hA0, 0, 0, 0, 0);
    exp_op(OP_START, 0, 8'h34); exp_op(OP_SEND, 0, 8'h5A); exp_op(OP_STOP, 0, 8'h00);
    run("R3 byte write", 3'd1, 8'h34, 8'h5A, 8'h99, 8'h00, -1, 0, RES_INTR, 0, 0, 0, 0, 0, 0);

    // R4: byte data and word data
    exp_op(OP_START, 0, 8'hA0); exp_op(OP_SEND, 0, 8'h10); exp_op(OP_START, 0, 8'hA1);
    exp_op(OP_RECV, 1, 8'h00); exp_op(OP_STOP, 0, 8'h00);
    run("R4 byte data read", 3'd2, 8'hA1, 8'h10, 8'h00, 8'h00, -1, 0, RES_INTR, 1, 8'hA0, 0, 0, 0, 0);
    exp_op(OP_START, 0, 8'hA0); exp_op(OP_SEND, 0, 8'h11); exp_op(OP_SEND, 0, 8'h77);
    exp_op(OP_STOP, 0, 8'h00);
    run("R4 byte data write", 3'd2, 8'hA0, 8'h11, 8'h77, 8'h00, -1, 0, RES_INTR, 0, 0, 0, 0, 0, 0);
    exp_op(OP_START, 0, 8'hA0); exp_op(OP_SEND, 0, 8'h22); exp_op(OP_START, 0, 8'hA1);
    exp_op(OP_RECV, 0, 8'h00); exp_op(OP_RECV, 1, 8'h00); exp_op(OP_STOP, 0, 8'h00);
    run("R4 word read", 3'd3, 8'hA1, 8'h22, 8'h00, 8'h00, -1, 0, RES_INTR, 1, 8'hA0, 1, 8'hA1, 0, 0);
    exp_op(OP_START, 0, 8'hA0); exp_op(OP_SEND, 0, 8'h33); exp_op(OP_SEND, 0, 8'hC4);
    exp_op(OP_SEND, 0, 8'h5B); exp_op(OP_STOP, 0, 8'h00);
    run("R4 word write", 3'd3, 8'hA0, 8'h33, 8'hC4, 8'h5B, -1, 0, RES_INTR, 0, 0, 0, 0, 0, 0);

    // R5: block read and write handoff, no stop
    exp_op(OP_START, 0, 8'h16); exp_op(OP_SEND, 0, 8'h44); exp_op(OP_START, 0, 8'h17);
    exp_op(OP_RECV, 0, 8'h00);
    run("R5 block read", 3'd5, 8'h17, 8'h44, 8'h00, 8'h00, -1, 0, RES_HAND, 1, 8'hA0, 0, 0, 0, 0);
    exp_op(OP_START, 0, 8'h16); exp_op(OP_SEND, 0, 8'h45); exp_op(OP_SEND, 0, 8'h03);
    run("R5 block write", 3'd5, 8'h16, 8'h45, 8'h03, 8'h00, -1, 0, RES_HAND, 0, 0, 0, 0, 0, 0);

    // R6: raw block read ignores the direction flag and sends data1
    exp_op(OP_START, 0, 8'h16); exp_op(OP_SEND, 0, 8'h08); exp_op(OP_START, 0, 8'h17);
    exp_op(OP_RECV, 0, 8'h00);
    run("R6 raw block read", 3'd6, 8'h17, 8'h99, 8'h00, 8'h08, -1, 0, RES_BYTE, 0, 0, 0, 0, 1, 8'hA0);

    // R7: unsupported codes
    run("R7 code 4", 3'd4, 8'h20, 8'h01, 8'h02, 8'h03, -1, 0, RES_ERR, 0, 0, 0, 0, 0, 0);
    run("R7 code 7", 3'd7, 8'h21, 8'h01, 8'h02, 8'h03, -1, 0, RES_ERR, 0, 0, 0, 0, 0, 0);

    // R8: NACK on address and on a data byte
    exp_op(OP_START, 0, 8'hA0); exp_op(OP_STOP, 0, 8'h00);
    run("R8 address nack", 3'd3, 8'hA0, 8'h33, 8'hC4, 8'h5B, 0, 0, RES_ERR, 0, 0, 0, 0, 0, 0);
    exp_op(OP_START, 0, 8'hA0); exp_op(OP_SEND, 0, 8'h33); exp_op(OP_SEND, 0, 8'hC4);
    exp_op(OP_STOP, 0, 8'h00);
    run("R8 data nack", 3'd3, 8'hA0, 8'h33, 8'hC4, 8'h5B, 2, 0, RES_ERR, 0, 0, 0, 0, 0, 0);
    exp_op(OP_START, 0, 8'hA0); exp_op(OP_SEND, 0, 8'h10); exp_op(OP_START, 0, 8'hA1);
    exp_op(OP_STOP, 0, 8'h00);
    run("R8 restart nack", 3'd2, 8'hA1, 8'h10, 8'h00, 8'h00, 2, 0, RES_ERR, 0, 0, 0, 0, 0, 0);

    // R9: stray start and operand changes during a word read
    exp_op(OP_START, 0, 8'hA0); exp_op(OP_SEND, 0, 8'h22); exp_op(OP_START, 0, 8'hA1);
    exp_op(OP_RECV, 0, 8'h00); exp_op(OP_RECV, 1, 8'h00); exp_op(OP_STOP, 0, 8'h00);
    run("R9 start while busy", 3'd3, 8'hA1, 8'h22, 8'h00, 8'h00, -1, 1, RES_INTR, 1, 8'hA0, 1, 8'hA1, 0, 0);
    cur_tag = "R9";
    check(!busy, "R9 no second transaction", busy, 0);

    finish_run();
  end

endmodule